// File: doc/BRIEF.md
# Real-to-Absolute Prefix Remap with Low-Storage Store Guard

This unit is one pipeline stage in the path from a real address to an absolute address. It swaps two 8 KB windows. Real addresses in the first 8 KB of storage are moved to the 8 KB area that starts at a programmable prefix. Addresses inside that prefix area are moved down to the start of storage. All other addresses pass through unchanged. The stage works on the page-aligned form of the request address, so the absolute address it returns always has its low 12 bits clear.

In the same cycle the stage applies a low-storage store guard. A global guard enable switches it on. When translation is off, the guard then applies unconditionally. When translation is on, the guard applies unless the private-space flag is set for the selected address space. A store to an exact byte address inside the guarded low range is refused with a protection fault. Any access to a page that holds guarded bytes raises a write-invalidate hint, so that a cached translation of that page is not reused for later writes. Selecting the access-register space while translation is on is an unsupported mode and produces an error response.

A small state machine holds the response class. Its states are IDLE (no response), GRANT (address produced), PROT (protection fault) and BADMODE (unsupported space). On every clock edge it takes one of the transitions IDLE/any to GRANT, PROT or BADMODE when a request is valid, and any state to IDLE when no request is valid. Reset returns it to IDLE.

Top module: `pfx_lowguard`

## Requirements
- R1: The prefix register resets to zero and loads `pfx_wdata` with its low 13 bits forced to zero on a clock edge where `pfx_we` is 1. A request presented in the same cycle as a write still uses the old prefix.
- R2: A request whose page-aligned address is below 0x2000 returns that page address plus the prefix.
- R3: A request whose page-aligned address lies in [prefix, prefix+0x2000) returns that address minus the prefix. Every other page address is returned unchanged, with bits 11:0 always zero.
- R4: Each valid request gives exactly one response: `rsp_valid` is 1 in the cycle after the request cycle and 0 after a cycle with no request. Back-to-back requests give back-to-back responses.
- R5: A guarded store (`req_kind` 01) whose exact address is in 0..511 or 4096..4607 gives `prot_fault`=1, `fault_code`=0x04 and `abs_addr`=0.
- R6: The guard is inactive when `guard_en` is 0. With `guard_en`=1 and `xlate_en`=0, it is active whatever the private-space flags are.
- R7: With `xlate_en`=1, the guard is active unless the private-space flag of the selected space is 1. The selector codes are 00 primary, 10 secondary and 11 home.
- R8: Loads (00), fetches (10) and code 11 never fault, and neither does a store outside the exact guarded range (for example 0x200 or 0x1200). These requests give `fault_code`=0x00 and the remapped address.
- R9: `wr_inval` is 1 when the guard is active and the address is below 0x2000, whether or not the request faults. Otherwise it is 0.
- R10: With `xlate_en`=1, selector 01 gives `mode_err`=1, `fault_code`=0x0F, `abs_addr`=0, `wr_inval`=0 and `prot_fault`=0. With `xlate_en`=0, selector 01 is ignored.
- R11: During reset and in idle cycles, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfx_we | input | 1 | Prefix register write enable |
| pfx_wdata | input | 64 | New prefix value (low 13 bits ignored) |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 64 | Real byte address |
| req_kind | input | 2 | 00 load, 01 store, 10 fetch |
| guard_en | input | 1 | Low-storage guard master enable |
| xlate_en | input | 1 | Address translation active |
| space_sel | input | 2 | 00 primary, 01 access-register, 10 secondary, 11 home |
| priv_primary | input | 1 | Private-space flag of primary space |
| priv_secondary | input | 1 | Private-space flag of secondary space |
| priv_home | input | 1 | Private-space flag of home space |
| rsp_valid | output | 1 | Response present |
| abs_addr | output | 64 | Page-aligned absolute address (0 on fault/error) |
| wr_inval | output | 1 | Write-invalidate hint for the page |
| prot_fault | output | 1 | Protection fault strobe |
| mode_err | output | 1 | Unsupported space selector |
| fault_code | output | 8 | 0x00 none, 0x04 protection, 0x0F bad mode |

## Verification
On every cycle the assertions check these rules:
- A response appears exactly one cycle after each request.
- A fault can only come from a store, and only from a store to an exact guarded address.
- A fault or error carries a zero address and the right code.
- Protection faults and mode errors never occur together.
- With the guard disabled, no protection fault is possible.

Only the bench scenarios can show the numeric result of the window swap against a chosen prefix. The same holds for the private-space choice for each selector, the invalidate hint at the page boundaries, and the timing of a prefix write against a request in the same cycle.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_OTHER = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        SP_PRIMARY   = 2'b00,
        SP_ACCREG    = 2'b01,
        SP_SECONDARY = 2'b10,
        SP_HOME      = 2'b11
    } space_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_GRANT   = 2'd1,
        ST_PROT    = 2'd2,
        ST_BADMODE = 2'd3
    } st_e;

    localparam logic [7:0] CODE_NONE = 8'h00;
    localparam logic [7:0] CODE_PROT = 8'h04;
    localparam logic [7:0] CODE_MODE = 8'h0F;

endpackage

// File: rtl/pfx_prefix_reg.sv
module pfx_prefix_reg #(
    parameter int AW        = 64,
    parameter int SWAP_BITS = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] prefix
);
    localparam logic [AW-1:0] ALIGN_MASK = {{(AW-SWAP_BITS){1'b1}}, {SWAP_BITS{1'b0}}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prefix <= '0;
        end else if (we) begin
            prefix <= wdata & ALIGN_MASK;
        end
    end
endmodule

// File: rtl/pfx_remap.sv
module pfx_remap #(
    parameter int AW        = 64,
    parameter int PAGE_BITS = 12,
    parameter int SWAP_BITS = 13
) (
    input  logic [AW-1:0] real_addr,
    input  logic [AW-1:0] prefix,
    output logic [AW-1:0] abs_addr
);
    localparam logic [AW-1:0] PAGE_MASK = {{(AW-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};
    localparam logic [AW-1:0] HI_MASK   = {{(AW-SWAP_BITS){1'b1}}, {SWAP_BITS{1'b0}}};

    logic [AW-1:0] page;
    logic          in_low_window;
    logic          in_pfx_window;

    always_comb begin
        page          = real_addr & PAGE_MASK;
        in_low_window = (page & HI_MASK) == '0;
        in_pfx_window = ((page ^ prefix) & HI_MASK) == '0;
        if (in_low_window) begin
            abs_addr = page + prefix;
        end else if (in_pfx_window) begin
            abs_addr = page - prefix;
        end else begin
            abs_addr = page;
        end
    end
endmodule

// File: rtl/pfx_guard.sv
module pfx_guard
    import pfx_pkg::*;
#(
    parameter int AW        = 64,
    parameter int PAGE_BITS = 12,
    parameter int SWAP_BITS = 13,
    parameter int LOW_BITS  = 9
) (
    input  logic [AW-1:0] addr,
    input  logic          guard_en,
    input  logic          xlate_en,
    input  logic [1:0]    space_sel,
    input  logic          priv_primary,
    input  logic          priv_secondary,
    input  logic          priv_home,
    output logic          active,
    output logic          page_low,
    output logic          exact_low,
    output logic          bad_mode
);
    localparam logic [AW-1:0] HI_MASK    = {{(AW-SWAP_BITS){1'b1}}, {SWAP_BITS{1'b0}}};
    localparam logic [AW-1:0] MID_MASK   = {{(AW-PAGE_BITS){1'b0}}, {(PAGE_BITS-LOW_BITS){1'b1}},
                                            {LOW_BITS{1'b0}}};
    localparam logic [AW-1:0] EXACT_MASK = HI_MASK | MID_MASK;

    logic sel_private;

    always_comb begin
        unique case (space_e'(space_sel))
            SP_PRIMARY:   sel_private = priv_primary;
            SP_SECONDARY: sel_private = priv_secondary;
            SP_HOME:      sel_private = priv_home;
            SP_ACCREG:    sel_private = 1'b0;
        endcase
        bad_mode  = xlate_en && (space_e'(space_sel) == SP_ACCREG);
        active    = guard_en && (!xlate_en || !sel_private);
        page_low  = (addr & HI_MASK) == '0;
        exact_low = (addr & EXACT_MASK) == '0;
    end
endmodule

// File: rtl/pfx_lowguard.sv
module pfx_lowguard
    import pfx_pkg::*;
#(
    parameter int AW           = 64,
    parameter int PAGE_BYTES   = 4096,
    parameter int WINDOW_BYTES = 8192,
    parameter int LOW_BYTES    = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pfx_we,
    input  logic [AW-1:0] pfx_wdata,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_kind,
    input  logic          guard_en,
    input  logic          xlate_en,
    input  logic [1:0]    space_sel,
    input  logic          priv_primary,
    input  logic          priv_secondary,
    input  logic          priv_home,
    output logic          rsp_valid,
    output logic [AW-1:0] abs_addr,
    output logic          wr_inval,
    output logic          prot_fault,
    output logic          mode_err,
    output logic [7:0]    fault_code
);
    localparam int PAGE_BITS = $clog2(PAGE_BYTES);
    localparam int SWAP_BITS = $clog2(WINDOW_BYTES);
    localparam int LOW_BITS  = $clog2(LOW_BYTES);

    logic [AW-1:0] prefix;
    logic [AW-1:0] abs_c;
    logic          g_active;
    logic          g_page_low;
    logic          g_exact_low;
    logic          g_bad_mode;

    st_e           state_q;
    st_e           state_d;
    logic [AW-1:0] abs_q;
    logic          inval_q;

    pfx_prefix_reg #(.AW(AW), .SWAP_BITS(SWAP_BITS)) u_prefix (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (pfx_we),
        .wdata  (pfx_wdata),
        .prefix (prefix)
    );

    pfx_remap #(.AW(AW), .PAGE_BITS(PAGE_BITS), .SWAP_BITS(SWAP_BITS)) u_remap (
        .real_addr (req_addr),
        .prefix    (prefix),
        .abs_addr  (abs_c)
    );

    pfx_guard #(.AW(AW), .PAGE_BITS(PAGE_BITS), .SWAP_BITS(SWAP_BITS),
                .LOW_BITS(LOW_BITS)) u_guard (
        .addr           (req_addr),
        .guard_en       (guard_en),
        .xlate_en       (xlate_en),
        .space_sel      (space_sel),
        .priv_primary   (priv_primary),
        .priv_secondary (priv_secondary),
        .priv_home      (priv_home),
        .active         (g_active),
        .page_low       (g_page_low),
        .exact_low      (g_exact_low),
        .bad_mode       (g_bad_mode)
    );

    // Next-state decision
    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) begin
            if (g_bad_mode) begin
                state_d = ST_BADMODE;
            end else if (g_active && g_exact_low && (acc_e'(req_kind) == ACC_STORE)) begin
                state_d = ST_PROT;
            end else begin
                state_d = ST_GRANT;
            end
        end
    end

    // State and captured data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            abs_q   <= '0;
            inval_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                abs_q   <= abs_c;
                inval_q <= g_active && g_page_low;
            end
        end
    end

    // Outputs from state
    always_comb begin
        rsp_valid  = 1'b0;
        abs_addr   = '0;
        wr_inval   = 1'b0;
        prot_fault = 1'b0;
        mode_err   = 1'b0;
        fault_code = CODE_NONE;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_GRANT: begin
                rsp_valid = 1'b1;
                abs_addr  = abs_q;
                wr_inval  = inval_q;
            end
            ST_PROT: begin
                rsp_valid  = 1'b1;
                wr_inval   = inval_q;
                prot_fault = 1'b1;
                fault_code = CODE_PROT;
            end
            ST_BADMODE: begin
                rsp_valid  = 1'b1;
                mode_err   = 1'b1;
                fault_code = CODE_MODE;
            end
        endcase
    end
endmodule

// File: rtl/pfx_lowguard_chk.sv
module pfx_lowguard_chk #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [AW-1:0] req_addr,
    input logic [1:0]    req_kind,
    input logic          guard_en,
    input logic          xlate_en,
    input logic [1:0]    space_sel,
    input logic          rsp_valid,
    input logic [AW-1:0] abs_addr,
    input logic          wr_inval,
    input logic          prot_fault,
    input logic          mode_err,
    input logic [7:0]    fault_code
);
    localparam logic [AW-1:0] EXACT = {{(AW-13){1'b1}}, 1'b0, 3'b111, 9'b0};

    AST_REQ_GETS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R4
    AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid)); // R4
    AST_FAULT_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault |-> ($past(req_kind) == 2'b01)); // R8
    AST_FAULT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault |-> (($past(req_addr) & EXACT) == '0)); // R5
    AST_FAULT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault |-> (abs_addr == '0 && fault_code == 8'h04 && rsp_valid)); // R5
    AST_NO_GUARD_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !guard_en) |=> !prot_fault); // R6
    AST_MODE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> ($past(xlate_en) && $past(space_sel) == 2'b01)); // R10
    AST_MODE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> (abs_addr == '0 && !wr_inval && fault_code == 8'h0F)); // R10
    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prot_fault, mode_err})); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (abs_addr == '0 && !wr_inval && fault_code == 8'h00)); // R11
    AST_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (abs_addr[11:0] == 12'h000)); // R3
endmodule

bind pfx_lowguard pfx_lowguard_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_kind   (req_kind),
    .guard_en   (guard_en),
    .xlate_en   (xlate_en),
    .space_sel  (space_sel),
    .rsp_valid  (rsp_valid),
    .abs_addr   (abs_addr),
    .wr_inval   (wr_inval),
    .prot_fault (prot_fault),
    .mode_err   (mode_err),
    .fault_code (fault_code)
);

// File: tb/sim_pfx_lowguard.sv
module sim_pfx_lowguard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pfx_we = 1'b0;
    logic [63:0] pfx_wdata = '0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        guard_en = 1'b0;
    logic        xlate_en = 1'b0;
    logic [1:0]  space_sel = '0;
    logic        priv_primary = 1'b0;
    logic        priv_secondary = 1'b0;
    logic        priv_home = 1'b0;
    logic        rsp_valid;
    logic [63:0] abs_addr;
    logic        wr_inval;
    logic        prot_fault;
    logic        mode_err;
    logic [7:0]  fault_code;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pfx_lowguard u0 (
        .clk(clk), .rst_n(rst_n), .pfx_we(pfx_we), .pfx_wdata(pfx_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind),
        .guard_en(guard_en), .xlate_en(xlate_en), .space_sel(space_sel),
        .priv_primary(priv_primary), .priv_secondary(priv_secondary),
        .priv_home(priv_home), .rsp_valid(rsp_valid), .abs_addr(abs_addr),
        .wr_inval(wr_inval), .prot_fault(prot_fault), .mode_err(mode_err),
        .fault_code(fault_code)
    );

    // priv = {home, secondary, primary}
    typedef struct packed {
        logic [63:0] addr;
        logic [1:0]  kind;
        logic        guard;
        logic        xlate;
        logic [1:0]  sel;
        logic [2:0]  priv;
        logic [63:0] eabs;
        logic        einval;
        logic        efault;
        logic        eerr;
    } vec_t;

    localparam int NV = 20;
    // prefix 0x46000 throughout the table
    localparam vec_t TBL [NV] = '{
        '{64'h0,     2'b00, 1'b0, 1'b0, 2'b00, 3'b000, 64'h46000, 1'b0, 1'b0, 1'b0}, // R2
        '{64'h1ABC,  2'b00, 1'b0, 1'b0, 2'b00, 3'b000, 64'h47000, 1'b0, 1'b0, 1'b0}, // R2
        '{64'h46123, 2'b00, 1'b0, 1'b0, 2'b00, 3'b000, 64'h0,     1'b0, 1'b0, 1'b0}, // R3
        '{64'h47FFF, 2'b00, 1'b0, 1'b0, 2'b00, 3'b000, 64'h1000,  1'b0, 1'b0, 1'b0}, // R3
        '{64'h48000, 2'b00, 1'b0, 1'b0, 2'b00, 3'b000, 64'h48000, 1'b0, 1'b0, 1'b0}, // R3
        '{64'h45FFF, 2'b00, 1'b0, 1'b0, 2'b00, 3'b000, 64'h45000, 1'b0, 1'b0, 1'b0}, // R3
        '{64'h100,   2'b01, 1'b1, 1'b0, 2'b00, 3'b111, 64'h0,     1'b1, 1'b1, 1'b0}, // R5
        '{64'h11FF,  2'b01, 1'b1, 1'b0, 2'b00, 3'b000, 64'h0,     1'b1, 1'b1, 1'b0}, // R5
        '{64'h200,   2'b01, 1'b1, 1'b0, 2'b00, 3'b000, 64'h46000, 1'b1, 1'b0, 1'b0}, // R8
        '{64'h1200,  2'b01, 1'b1, 1'b0, 2'b00, 3'b000, 64'h47000, 1'b1, 1'b0, 1'b0}, // R8
        '{64'h0,     2'b00, 1'b1, 1'b0, 2'b00, 3'b000, 64'h46000, 1'b1, 1'b0, 1'b0}, // R8
        '{64'h10,    2'b10, 1'b1, 1'b0, 2'b00, 3'b000, 64'h46000, 1'b1, 1'b0, 1'b0}, // R9
        '{64'h2000,  2'b01, 1'b1, 1'b0, 2'b00, 3'b000, 64'h2000,  1'b0, 1'b0, 1'b0}, // R9
        '{64'h0,     2'b01, 1'b0, 1'b0, 2'b00, 3'b000, 64'h46000, 1'b0, 1'b0, 1'b0}, // R6
        '{64'h0,     2'b01, 1'b1, 1'b1, 2'b00, 3'b001, 64'h46000, 1'b0, 1'b0, 1'b0}, // R7
        '{64'h0,     2'b01, 1'b1, 1'b1, 2'b00, 3'b110, 64'h0,     1'b1, 1'b1, 1'b0}, // R7
        '{64'h0,     2'b01, 1'b1, 1'b1, 2'b10, 3'b010, 64'h46000, 1'b0, 1'b0, 1'b0}, // R7
        '{64'h0,     2'b01, 1'b1, 1'b1, 2'b11, 3'b011, 64'h0,     1'b1, 1'b1, 1'b0}, // R7
        '{64'h0,     2'b01, 1'b1, 1'b1, 2'b01, 3'b000, 64'h0,     1'b0, 1'b0, 1'b1}, // R10
        '{64'h300,   2'b01, 1'b1, 1'b0, 2'b01, 3'b000, 64'h46000, 1'b1, 1'b0, 1'b0}  // R10
    };

    function automatic string tag_of(int i);
        if (i < 2)  return "R2";
        if (i < 6)  return "R3";
        if (i < 8)  return "R5";
        if (i < 11) return "R8";
        if (i < 13) return "R9";
        if (i < 14) return "R6";
        if (i < 18) return "R7";
        return "R10";
    endfunction

    task automatic check(string rq, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic set_req(logic [63:0] a, logic [1:0] k, logic g, logic x,
                           logic [1:0] s, logic [2:0] p);
        req_valid      = 1'b1;
        req_addr       = a;
        req_kind       = k;
        guard_en       = g;
        xlate_en       = x;
        space_sel      = s;
        priv_primary   = p[0];
        priv_secondary = p[1];
        priv_home      = p[2];
    endtask

    task automatic send(logic [63:0] a, logic [1:0] k, logic g, logic x,
                        logic [1:0] s, logic [2:0] p);
        @(negedge clk);
        set_req(a, k, g, x, s, p);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic write_prefix(logic [63:0] v);
        @(negedge clk);
        pfx_we    = 1'b1;
        pfx_wdata = v;
        @(negedge clk);
        pfx_we    = 1'b0;
    endtask

    task automatic check_quiet(string rq);
        check(rq, "rsp_valid", 64'(rsp_valid), 64'd0);
        check(rq, "abs_addr", abs_addr, 64'd0);
        check(rq, "flags", {61'd0, wr_inval, prot_fault, mode_err}, 64'd0);
        check(rq, "fault_code", 64'(fault_code), 64'd0);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_quiet("R11");
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R11");

        write_prefix(64'h46000);

        for (int i = 0; i < NV; i++) begin
            send(TBL[i].addr, TBL[i].kind, TBL[i].guard, TBL[i].xlate, TBL[i].sel, TBL[i].priv);
            check("R4", "rsp_valid", 64'(rsp_valid), 64'd1);
            check(tag_of(i), "abs_addr", abs_addr, TBL[i].eabs);
            check(tag_of(i), "wr_inval", 64'(wr_inval), 64'(TBL[i].einval));
            check(tag_of(i), "prot_fault", 64'(prot_fault), 64'(TBL[i].efault));
            check(tag_of(i), "mode_err", 64'(mode_err), 64'(TBL[i].eerr));
            check(tag_of(i), "fault_code", 64'(fault_code),
                  TBL[i].eerr ? 64'h0F : (TBL[i].efault ? 64'h04 : 64'h00));
            @(negedge clk);
            check("R4", "idle rsp_valid", 64'(rsp_valid), 64'd0);
        end

        // R1: low bits of written prefix are dropped
        write_prefix(64'h1_0000_3FFF);
        send(64'h0, 2'b00, 1'b0, 1'b0, 2'b00, 3'b000);
        check("R1", "masked prefix", abs_addr, 64'h1_0000_2000);
        // R3: window at a high prefix maps down
        send(64'h1_0000_3ABC, 2'b00, 1'b0, 1'b0, 2'b00, 3'b000);
        check("R3", "high window", abs_addr, 64'h1000);

        // R1: same-cycle write and request uses old prefix
        @(negedge clk);
        pfx_we    = 1'b1;
        pfx_wdata = 64'h8000;
        set_req(64'h0, 2'b00, 1'b0, 1'b0, 2'b00, 3'b000);
        @(negedge clk);
        pfx_we    = 1'b0;
        req_valid = 1'b0;
        check("R1", "old prefix in write cycle", abs_addr, 64'h1_0000_2000);
        send(64'h0, 2'b00, 1'b0, 1'b0, 2'b00, 3'b000);
        check("R1", "new prefix", abs_addr, 64'h8000);

        // R4: back-to-back requests
        @(negedge clk);
        set_req(64'h0, 2'b00, 1'b0, 1'b0, 2'b00, 3'b000);
        @(negedge clk);
        check("R4", "b2b first abs", abs_addr, 64'h8000);
        set_req(64'h0, 2'b01, 1'b1, 1'b0, 2'b00, 3'b000);
        @(negedge clk);
        req_valid = 1'b0;
        check("R4", "b2b second valid", 64'(rsp_valid), 64'd1);
        check("R5", "b2b second fault", 64'(prot_fault), 64'd1);
        @(negedge clk);
        check("R4", "b2b idle", 64'(rsp_valid), 64'd0);

        // R11: reset mid-run clears outputs and the prefix
        @(negedge clk);
        set_req(64'h0, 2'b00, 1'b1, 1'b0, 2'b00, 3'b000);
        @(negedge clk);
        req_valid = 1'b0;
        rst_n     = 1'b0;
        @(negedge clk);
        check_quiet("R11");
        rst_n = 1'b1;
        send(64'h1000, 2'b00, 1'b0, 1'b0, 2'b00, 3'b000);
        check("R1", "prefix after reset", abs_addr, 64'h1000);

        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule